// File: doc/BRIEF.md
# Qualified-Strobe Bus State Capture

This block is the state-mode front end of an on-chip bus analyzer for a classic 8-bit processor bus. It oversamples the processor's control strobes, address and data with a fast system clock. It forms a capture event when the memory-request or I/O-request strobe is released. An optional qualifier drops refresh cycles. At each event the block records one combined word that holds a 4-bit status, the address and the data.

After reset the block is armed. It compares each qualified event against a masked trigger on address and status. Nothing is stored until that comparison hits. From then on every qualified event produces one write into an external capture memory, at consecutive addresses. After the configured number of entries the block raises a sticky done flag and ignores the bus until the next reset.

The controller has three named states. ST_ARMED moves to ST_CAPTURE on a trigger hit, or straight to ST_DONE when the depth is 1. ST_CAPTURE moves to ST_DONE on the event that fills the last entry. ST_DONE has no exit except reset.

Top module: `bus_state_capture`

## Requirements
- R1: While armed, no capture-memory write occurs until a qualified event matches the trigger. The trigger is tested only on qualified events, and the matching event is stored as entry 0.
- R2: The status nibble is built as follows: bit 0 = inverted write pin, bit 1 = inverted I/O-request pin, bit 2 = refresh pin as is, bit 3 = machine-cycle-one pin as is.
- R3: A capture event is the release of the memory-request pin or of the I/O-request pin (low to high), seen after synchronization. Releasing both pins on the same clock produces exactly one entry.
- R4: With `qual_en` = 1, an event whose refresh pin was low is neither stored nor tested against the trigger. With `qual_en` = 0, that event is treated like any other.
- R5: Each entry is {status[3:0], address[15:0], data[7:0]}, with status in the top bits. It carries the values present while the strobe was still asserted, even if address, data and status change on the same clock as the release.
- R6: Write addresses start at 0 after reset and increase by one per stored entry.
- R7: `cap_done` rises on the same clock as the write of entry DEPTH-1. After that no further writes occur, and `cap_done` stays high until reset.
- R8: During and right after reset, `cap_wr_en` and `cap_done` are 0.
- R9: A trigger mask bit of 0 makes that address or status bit a don't-care. A mask bit of 1 requires that bit to equal the pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset; re-arms the block |
| bus_mreq_n | input | 1 | Memory-request strobe, active low |
| bus_iorq_n | input | 1 | I/O-request strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rfsh_n | input | 1 | Refresh indicator, active low |
| bus_m1_n | input | 1 | Machine-cycle-one indicator, active low |
| bus_addr | input | 16 | Processor address bus |
| bus_data | input | 8 | Processor data bus |
| qual_en | input | 1 | 1 = discard events that occur during refresh |
| trig_addr | input | 16 | Trigger address pattern |
| trig_addr_mask | input | 16 | Trigger address care mask (1 = compare) |
| trig_stat | input | 4 | Trigger status pattern |
| trig_stat_mask | input | 4 | Trigger status care mask (1 = compare) |
| cap_wr_en | output | 1 | Capture memory write strobe, one cycle per entry |
| cap_wr_addr | output | 3 | Capture memory write address |
| cap_wr_data | output | 28 | Captured entry {status, address, data} |
| cap_done | output | 1 | Buffer full; sticky until reset |

## Verification
The hardest situation to reach from the ports is a memory-request and an I/O-request release that land on the very same oversampled edge, because normal bus traffic never produces one. The bench drives an interrupt-acknowledge style cycle that asserts both strobes together and releases them in the same bench cycle, and then checks that a single entry appears with the I/O bit set. The bench also changes address, data and status on the same clock as every strobe release. This shows that the stored word comes from before the release and not from after it.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    localparam int STAT_W = 4;
    // status nibble bit positions (decoded by downstream disassembly)
    localparam int ST_WR_BIT = 0;
    localparam int ST_IO_BIT = 1;
    localparam int ST_RF_BIT = 2;
    localparam int ST_M1_BIT = 3;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_DONE    = 2'd2
    } cap_state_e;
endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
    parameter int           W       = 8,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe[s] <= RST_VAL;
                end else if (s == 0) begin
                    pipe[s] <= din;
                end else begin
                    pipe[s] <= pipe[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/bsc_strobe_qual.sv
module bsc_strobe_qual
    import bsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              wr_n,
    input  logic              rfsh_n,
    input  logic              m1_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              qual_en,
    output logic              evt,
    output logic [STAT_W-1:0] snap_stat,
    output logic [ADDR_W-1:0] snap_addr,
    output logic [DATA_W-1:0] snap_data
);
    // one-cycle-old copy of the synchronized bus
    logic              h_mreq_n, h_iorq_n, h_wr_n, h_rfsh_n, h_m1_n;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_mreq_n <= 1'b1;
            h_iorq_n <= 1'b1;
            h_wr_n   <= 1'b1;
            h_rfsh_n <= 1'b1;
            h_m1_n   <= 1'b1;
            h_addr   <= '0;
            h_data   <= '0;
        end else begin
            h_mreq_n <= mreq_n;
            h_iorq_n <= iorq_n;
            h_wr_n   <= wr_n;
            h_rfsh_n <= rfsh_n;
            h_m1_n   <= m1_n;
            h_addr   <= addr;
            h_data   <= data;
        end
    end

    // derived clocks: J = inverted mem request, K = inverted io request, L = refresh as is
    logic j_now, j_old, k_now, k_old, l_old, fall_j, fall_k;
    assign j_now  = ~mreq_n;
    assign j_old  = ~h_mreq_n;
    assign k_now  = ~iorq_n;
    assign k_old  = ~h_iorq_n;
    assign l_old  = h_rfsh_n;
    assign fall_j = j_old & ~j_now;
    assign fall_k = k_old & ~k_now;
    assign evt    = (fall_j | fall_k) & (~qual_en | l_old);

    always_comb begin
        snap_stat            = '0;
        snap_stat[ST_WR_BIT] = ~h_wr_n;
        snap_stat[ST_IO_BIT] = ~h_iorq_n;
        snap_stat[ST_RF_BIT] = h_rfsh_n;
        snap_stat[ST_M1_BIT] = h_m1_n;
    end
    assign snap_addr = h_addr;
    assign snap_data = h_data;
endmodule

// File: rtl/bsc_capture_fsm.sv
module bsc_capture_fsm
    import bsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int ENT_W = STAT_W + ADDR_W + DATA_W,
    localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [STAT_W-1:0] snap_stat,
    input  logic [ADDR_W-1:0] snap_addr,
    input  logic [DATA_W-1:0] snap_data,
    input  logic [ADDR_W-1:0] trig_addr,
    input  logic [ADDR_W-1:0] trig_addr_mask,
    input  logic [STAT_W-1:0] trig_stat,
    input  logic [STAT_W-1:0] trig_stat_mask,
    output logic              wr_en,
    output logic [CNT_W-1:0]  wr_addr,
    output logic [ENT_W-1:0]  wr_data,
    output logic              done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

    cap_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             hit, store;

    assign hit = evt
               && (((snap_addr ^ trig_addr) & trig_addr_mask) == '0)
               && (((snap_stat ^ trig_stat) & trig_stat_mask) == '0);

    always_comb begin
        state_d = state_q;
        store   = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (hit) begin
                    store   = 1'b1;
                    state_d = (DEPTH == 1) ? ST_DONE : ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                if (evt) begin
                    store = 1'b1;
                    if (cnt_q == LAST) state_d = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_ARMED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // outputs and write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            wr_en <= store;
            done  <= (state_d == ST_DONE);
            if (store) begin
                wr_addr <= cnt_q;
                wr_data <= {snap_stat, snap_addr, snap_data};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_no_write_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wr_en);
    p_done_at_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (wr_en && wr_addr == LAST));
endmodule

// File: rtl/bus_state_capture.sv
module bus_state_capture
    import bsc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ENT_W = STAT_W + ADDR_W + DATA_W,
    localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_mreq_n,
    input  logic              bus_iorq_n,
    input  logic              bus_wr_n,
    input  logic              bus_rfsh_n,
    input  logic              bus_m1_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              qual_en,
    input  logic [ADDR_W-1:0] trig_addr,
    input  logic [ADDR_W-1:0] trig_addr_mask,
    input  logic [STAT_W-1:0] trig_stat,
    input  logic [STAT_W-1:0] trig_stat_mask,
    output logic              cap_wr_en,
    output logic [CNT_W-1:0]  cap_wr_addr,
    output logic [ENT_W-1:0]  cap_wr_data,
    output logic              cap_done
);
    localparam int VEC_W = 5 + ADDR_W + DATA_W;
    localparam logic [VEC_W-1:0] VEC_RST = {5'b11111, {(ADDR_W + DATA_W){1'b0}}};

    logic [VEC_W-1:0]  raw_vec, syn_vec;
    logic              s_mreq_n, s_iorq_n, s_wr_n, s_rfsh_n, s_m1_n;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_data;
    logic              evt;
    logic [STAT_W-1:0] snap_stat;
    logic [ADDR_W-1:0] snap_addr;
    logic [DATA_W-1:0] snap_data;

    assign raw_vec = {bus_mreq_n, bus_iorq_n, bus_wr_n, bus_rfsh_n, bus_m1_n, bus_addr, bus_data};
    assign {s_mreq_n, s_iorq_n, s_wr_n, s_rfsh_n, s_m1_n, s_addr, s_data} = syn_vec;

    bsc_sync #(.W(VEC_W), .STAGES(SYNC_STAGES), .RST_VAL(VEC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_vec), .dout(syn_vec)
    );

    bsc_strobe_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qual (
        .clk(clk), .rst_n(rst_n),
        .mreq_n(s_mreq_n), .iorq_n(s_iorq_n), .wr_n(s_wr_n),
        .rfsh_n(s_rfsh_n), .m1_n(s_m1_n), .addr(s_addr), .data(s_data),
        .qual_en(qual_en), .evt(evt),
        .snap_stat(snap_stat), .snap_addr(snap_addr), .snap_data(snap_data)
    );

    bsc_capture_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .evt(evt),
        .snap_stat(snap_stat), .snap_addr(snap_addr), .snap_data(snap_data),
        .trig_addr(trig_addr), .trig_addr_mask(trig_addr_mask),
        .trig_stat(trig_stat), .trig_stat_mask(trig_stat_mask),
        .wr_en(cap_wr_en), .wr_addr(cap_wr_addr), .wr_data(cap_wr_data),
        .done(cap_done)
    );

    // independent count of writes seen at the port
    logic [CNT_W-1:0] chk_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)         chk_cnt <= '0;
        else if (cap_wr_en) chk_cnt <= chk_cnt + 1'b1;
    end

    p_addr_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_wr_en |-> (cap_wr_addr == chk_cnt));
    p_refresh_filtered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_wr_en && $past(qual_en)) |-> cap_wr_data[ADDR_W + DATA_W + ST_RF_BIT]);
endmodule

// File: tb/test_bus_state_capture.sv
module test_bus_state_capture;
    localparam int AW = 16, DW = 8, DEPTH = 8, CW = 3, EW = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mreq_n = 1'b1, iorq_n = 1'b1, wr_n = 1'b1, rfsh_n = 1'b1, m1_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic qual_en = 1'b0;
    logic [AW-1:0] t_addr = '0, t_amask = '0;
    logic [3:0] t_stat = '0, t_smask = '0;
    logic wr_en, done;
    logic [CW-1:0] wr_addr;
    logic [EW-1:0] wr_data;

    int n_chk = 0, n_bad = 0;
    logic [CW-1:0] q_a[$];
    logic [EW-1:0] q_d[$];

    always #2 clk = ~clk;

    bus_state_capture i_bus_state_capture (
        .clk(clk), .rst_n(rst_n),
        .bus_mreq_n(mreq_n), .bus_iorq_n(iorq_n), .bus_wr_n(wr_n),
        .bus_rfsh_n(rfsh_n), .bus_m1_n(m1_n), .bus_addr(addr), .bus_data(data),
        .qual_en(qual_en), .trig_addr(t_addr), .trig_addr_mask(t_amask),
        .trig_stat(t_stat), .trig_stat_mask(t_smask),
        .cap_wr_en(wr_en), .cap_wr_addr(wr_addr), .cap_wr_data(wr_data),
        .cap_done(done)
    );

    always @(negedge clk) if (rst_n && wr_en) begin
        q_a.push_back(wr_addr);
        q_d.push_back(wr_data);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic restart(input logic qe, input logic [AW-1:0] ta, input logic [AW-1:0] am,
                           input logic [3:0] ts, input logic [3:0] sm);
        @(negedge clk);
        rst_n = 1'b0; qual_en = qe; t_addr = ta; t_amask = am; t_stat = ts; t_smask = sm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        q_a.delete(); q_d.delete();
        repeat (2) @(negedge clk);
    endtask

    // sel: 1 = memory request, 2 = io request, 3 = both
    task automatic cyc(input logic [1:0] sel, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic w_n, input logic m_n, input logic r_n);
        @(negedge clk);
        addr = a; data = d; wr_n = w_n; m1_n = m_n; rfsh_n = r_n;
        mreq_n = ~sel[0]; iorq_n = ~sel[1];
        repeat (4) @(negedge clk);
        // release strobes and disturb everything on the same clock
        mreq_n = 1'b1; iorq_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1; rfsh_n = 1'b1;
        addr = '1; data = '1;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [31:0] ent(input logic [3:0] s, input logic [AW-1:0] a, input logic [DW-1:0] d);
        return {4'h0, s, a, d};
    endfunction

    task automatic t_reset_state();
        check("R8 wr_en after reset", {31'd0, wr_en}, 32'd0);
        check("R8 done after reset", {31'd0, done}, 32'd0);
    endtask

    task automatic t_trigger();
        restart(1'b0, 16'h1234, 16'hFFFF, 4'h0, 4'h0);
        cyc(2'd1, 16'h1000, 8'h01, 1'b1, 1'b1, 1'b1);
        cyc(2'd1, 16'h1001, 8'h02, 1'b1, 1'b1, 1'b1);
        check("R1 nothing stored before trigger", q_a.size(), 0);
        cyc(2'd1, 16'h1234, 8'h5A, 1'b1, 1'b1, 1'b1);
        cyc(2'd1, 16'h2000, 8'h33, 1'b0, 1'b1, 1'b1);
        check("R1 entries after trigger", q_a.size(), 2);
        if (q_a.size() == 2) begin
            check("R1 trigger entry at address 0", {29'd0, q_a[0]}, 0);
            check("R5 trigger entry value", {4'h0, q_d[0]}, ent(4'hC, 16'h1234, 8'h5A));
            check("R6 second address", {29'd0, q_a[1]}, 1);
            check("R5 write entry value", {4'h0, q_d[1]}, ent(4'hD, 16'h2000, 8'h33));
        end
    endtask

    task automatic t_status_order();
        logic [3:0] exp_s[6] = '{4'h4, 4'hC, 4'hD, 4'hF, 4'hE, 4'h8};
        restart(1'b0, 16'h0, 16'h0, 4'h0, 4'h0);
        cyc(2'd1, 16'h0100, 8'h10, 1'b1, 1'b0, 1'b1); // opcode fetch
        cyc(2'd1, 16'h0101, 8'h11, 1'b1, 1'b1, 1'b1); // mem read
        cyc(2'd1, 16'h0102, 8'h12, 1'b0, 1'b1, 1'b1); // mem write
        cyc(2'd2, 16'h0103, 8'h13, 1'b0, 1'b1, 1'b1); // io write
        cyc(2'd2, 16'h0104, 8'h14, 1'b1, 1'b1, 1'b1); // io read
        cyc(2'd1, 16'h0105, 8'h15, 1'b1, 1'b1, 1'b0); // refresh, unfiltered
        check("R4 refresh kept when qual_en=0", q_a.size(), 6);
        for (int i = 0; i < 6 && i < q_d.size(); i++)
            check($sformatf("R2 status entry %0d", i), {4'h0, q_d[i]},
                  ent(exp_s[i], 16'h0100 + 16'(i), 8'h10 + 8'(i)));
    endtask

    task automatic t_refresh_filter();
        restart(1'b1, 16'h0040, 16'hFFFF, 4'h0, 4'h0);
        cyc(2'd1, 16'h0040, 8'h99, 1'b1, 1'b1, 1'b0);
        check("R4 refresh ignored by trigger", q_a.size(), 0);
        cyc(2'd1, 16'h0040, 8'h11, 1'b1, 1'b1, 1'b1);
        cyc(2'd1, 16'h0041, 8'h98, 1'b1, 1'b1, 1'b0);
        cyc(2'd1, 16'h0042, 8'h22, 1'b1, 1'b1, 1'b1);
        check("R4 refresh not stored", q_a.size(), 2);
        if (q_d.size() == 2)
            check("R4 entry after skipped refresh", {4'h0, q_d[1]}, ent(4'hC, 16'h0042, 8'h22));
    endtask

    task automatic t_simultaneous();
        restart(1'b0, 16'h0, 16'h0, 4'h0, 4'h0);
        cyc(2'd3, 16'h0038, 8'hFF, 1'b1, 1'b0, 1'b1);
        check("R3 one entry for joint release", q_a.size(), 1);
        if (q_d.size() >= 1)
            check("R3 joint entry value", {4'h0, q_d[0]}, ent(4'h6, 16'h0038, 8'hFF));
        cyc(2'd1, 16'h0039, 8'h44, 1'b1, 1'b1, 1'b1);
        if (q_a.size() == 2) check("R6 address after joint entry", {29'd0, q_a[1]}, 1);
        else check("R3 entries after follow-up", q_a.size(), 2);
    endtask

    task automatic t_mask();
        restart(1'b0, 16'h12F0, 16'hFFF0, 4'h1, 4'h1);
        cyc(2'd1, 16'h12F5, 8'h01, 1'b1, 1'b1, 1'b1); // status mismatch
        cyc(2'd1, 16'h13F5, 8'h02, 1'b0, 1'b1, 1'b1); // address mismatch
        check("R9 no trigger on masked mismatch", q_a.size(), 0);
        cyc(2'd1, 16'h12FA, 8'h77, 1'b0, 1'b1, 1'b1);
        check("R9 trigger on masked match", q_a.size(), 1);
        if (q_d.size() >= 1)
            check("R9 matched entry", {4'h0, q_d[0]}, ent(4'hD, 16'h12FA, 8'h77));
    endtask

    task automatic t_depth();
        restart(1'b0, 16'h0, 16'h0, 4'h0, 4'h0);
        for (int i = 0; i < DEPTH + 3; i++) begin
            cyc(2'd1, 16'h3000 + 16'(i), 8'(i), 1'b1, 1'b1, 1'b1);
            if (i == DEPTH - 2) check("R7 done low before last entry", {31'd0, done}, 0);
        end
        check("R7 writes stop at depth", q_a.size(), DEPTH);
        check("R7 done high and held", {31'd0, done}, 1);
        for (int i = 0; i < DEPTH && i < q_a.size(); i++)
            check($sformatf("R6 address of entry %0d", i), {29'd0, q_a[i]}, i);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_trigger();
        t_status_order();
        t_refresh_filter();
        t_simultaneous();
        t_mask();
        t_depth();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule